// File: doc/BRIEF.md
# Two-Wire Serial Slave Engine

This block is the bus-side half of a small register-mapped peripheral. It watches an open-drain two-wire bus (a clock line and a data line) through its own fast system clock. Each line passes through a two-stage synchronizer and a short majority filter. The block then spots start and stop conditions and moves bytes most significant bit first. A device-select byte is matched against a fixed 4-bit prefix and three strap pins. After a match, the engine either stores one data byte into an attached register block, or streams register contents back to the master for as long as the master keeps acknowledging.

The attached register block provides the read data for the current pointer (`reg_addr`) combinationally. It takes a one-cycle write strobe and raises `busy` while it cannot serve the bus, for example during power-up or a non-volatile programming cycle. A pulse on `wr_stop` tells it that a STOP followed an accepted write, so it can start any non-volatile update. The engine only pulls the data line low through `sda_oe`; the pad turns that into an open-drain driver.

The controller has nine states: IDLE, DEV (device byte shifting in), DEV_ACK, ADR (register address shifting in), ADR_ACK, WR (data byte shifting in), WR_ACK, RD (byte shifting out) and RD_ACK (master acknowledge slot).

Transitions on a filtered clock fall:
- DEV goes to DEV_ACK on a match or to IDLE on a mismatch.
- DEV_ACK goes to RD for a read select or to ADR for a write select.
- ADR goes to ADR_ACK, and ADR_ACK goes to WR.
- WR goes to WR_ACK when write enable is high, or to IDLE when it is low.
- WR_ACK goes to IDLE.
- RD goes to RD_ACK.
- RD_ACK goes to RD on a master acknowledge or to IDLE on a not-acknowledge.

Any state goes to DEV on START and to IDLE on STOP. `busy` forces IDLE and has priority over both.

Top module: `twowire_slave`

## Requirements
- R1: After reset `sda_oe`, `reg_we` and `wr_stop` are all 0.
- R2: A START is the data line falling while the clock line is high. A STOP is the data line rising while the clock line is high. A STOP abandons any transfer in progress, and bytes clocked after it with no new START get no acknowledge and store nothing.
- R3: The device byte is acknowledged (data line held low during the ninth clock) only if its top four bits are 1010 and bits 3..1 equal `strap[2:0]`. Bit 0 of the device byte selects read (1) or write (0). A mismatch is not acknowledged and sends the engine to IDLE.
- R4: In a write, the second byte sets the register pointer (its low `ADDR_W` bits) and is acknowledged. The third byte is acknowledged and appears on `reg_wdata` with a single-cycle `reg_we`, issued at the clock fall that completes its last bit.
- R5: When `wp_n` is 0 at the fall that completes a data byte, the byte is not acknowledged, `reg_we` stays 0 and the engine goes to IDLE.
- R6: In a read, after the device byte with bit 0 = 1 is acknowledged, the engine sends the byte at the pointer MSB first. It moves to the next byte each time the master acknowledges.
- R7: The pointer advances after every byte sent. After `LAST_ADDR` (8) it wraps to 0.
- R8: A master not-acknowledge ends the read: the engine releases the data line and goes to IDLE.
- R9: While `busy` is 1, START conditions are ignored and `sda_oe` is 0 from the next cycle on.
- R10: `wr_stop` pulses for one cycle on a STOP that follows an accepted data byte. It does not pulse after a read or after a refused write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 3 | Device-select strap pins |
| wp_n | input | 1 | Active-low write protect |
| busy | input | 1 | Register block cannot serve the bus |
| reg_addr | output | ADDR_W | Register pointer |
| reg_rdata | input | 8 | Register contents at `reg_addr` |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle store strobe |
| wr_stop | output | 1 | STOP after an accepted write |

## Verification
The assertions assume that `wp_n` is steady around a data byte's last clock fall. They also assume the bus lines change slowly compared with the filter delay, so a START, STOP or data edge reaches the controller in the same order it happened on the bus. The bench's bit-level master holds every bus phase for twelve system clocks, well beyond the five-cycle filter latency. It changes the data line only a full phase after each clock fall, and changes `wp_n`, `busy` and the straps only while the bus is idle.

// File: rtl/tw_pkg.sv
`timescale 1ns/1ps
package tw_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_ADR,
        S_ADR_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } tw_state_t;
endpackage

// File: rtl/tw_deglitch.sv
`timescale 1ns/1ps
// Two-flop synchronizer followed by an odd-length majority vote.
module tw_deglitch #(
    parameter int DEPTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int HALF = DEPTH / 2;

    logic [1:0]       sync_q;
    logic [DEPTH-1:0] hist_q;

    function automatic int ones(input logic [DEPTH-1:0] v);
        int n = 0;
        for (int i = 0; i < DEPTH; i++) n += int'(v[i]);
        return n;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], din};
            hist_q <= {hist_q[DEPTH-2:0], sync_q[1]};
            dout   <= (ones(hist_q) > HALF);
        end
    end
endmodule

// File: rtl/tw_linecond.sv
`timescale 1ns/1ps
// Bus condition and clock edge detector on filtered lines.
module tw_linecond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign ev_start = scl_q & scl_f & sda_q & ~sda_f;
    assign ev_stop  = scl_q & scl_f & ~sda_q & sda_f;
    assign ev_rise  = ~scl_q & scl_f;
    assign ev_fall  = scl_q & ~scl_f;
endmodule

// File: rtl/twowire_slave.sv
`timescale 1ns/1ps
module twowire_slave
    import tw_pkg::*;
#(
    parameter int         ADDR_W     = 4,
    parameter int         LAST_ADDR  = 8,
    parameter int         FILT_DEPTH = 3,
    parameter logic [3:0] ID_PREFIX  = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        strap,
    input  logic              wp_n,
    input  logic              busy,
    output logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_rdata,
    output logic [7:0]        reg_wdata,
    output logic              reg_we,
    output logic              wr_stop
);
    localparam logic [ADDR_W-1:0] PTR_LAST = ADDR_W'(LAST_ADDR);
    localparam logic [3:0]        BITS     = 4'd8;

    // Filtered lines: index 1 is the clock, index 0 the data.
    logic [1:0] raw, filt;
    assign raw = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_flt
        tw_deglitch #(.DEPTH(FILT_DEPTH)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    logic ev_start, ev_stop, ev_rise, ev_fall;
    tw_linecond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (filt[1]),
        .sda_f   (filt[0]),
        .ev_start(ev_start),
        .ev_stop (ev_stop),
        .ev_rise (ev_rise),
        .ev_fall (ev_fall)
    );

    tw_state_t         state_q, state_d;
    logic [7:0]        shreg_q, tx_q;
    logic [3:0]        bitcnt_q;
    logic [ADDR_W-1:0] ptr_q, ptr_next;
    logic              rnw_q, mack_q, wr_ok_q;
    logic              byte_done, id_ok;

    assign byte_done = (bitcnt_q == BITS);
    assign id_ok     = (shreg_q[7:4] == ID_PREFIX) && (shreg_q[3:1] == strap);
    assign ptr_next  = (ptr_q == PTR_LAST) ? '0 : ptr_q + ADDR_W'(1);
    assign reg_addr  = ptr_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = S_IDLE;
        end else if (ev_start) begin
            state_d = S_DEV;
        end else if (ev_stop) begin
            state_d = S_IDLE;
        end else if (ev_fall) begin
            unique case (state_q)
                S_IDLE:    state_d = S_IDLE;
                S_DEV:     if (byte_done) state_d = id_ok ? S_DEV_ACK : S_IDLE;
                S_DEV_ACK: state_d = rnw_q ? S_RD : S_ADR;
                S_ADR:     if (byte_done) state_d = S_ADR_ACK;
                S_ADR_ACK: state_d = S_WR;
                S_WR:      if (byte_done) state_d = wp_n ? S_WR_ACK : S_IDLE;
                S_WR_ACK:  state_d = S_IDLE;
                S_RD:      if (byte_done) state_d = S_RD_ACK;
                S_RD_ACK:  state_d = mack_q ? S_RD : S_IDLE;
                default:   state_d = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe    <= 1'b0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
            wr_stop   <= 1'b0;
            shreg_q   <= '0;
            tx_q      <= '0;
            bitcnt_q  <= '0;
            ptr_q     <= '0;
            rnw_q     <= 1'b0;
            mack_q    <= 1'b0;
            wr_ok_q   <= 1'b0;
        end else begin
            reg_we  <= 1'b0;
            wr_stop <= 1'b0;
            if (busy) begin
                sda_oe   <= 1'b0;
                bitcnt_q <= '0;
                wr_ok_q  <= 1'b0;
            end else if (ev_start) begin
                sda_oe   <= 1'b0;
                bitcnt_q <= '0;
                wr_ok_q  <= 1'b0;
            end else if (ev_stop) begin
                sda_oe   <= 1'b0;
                wr_stop  <= wr_ok_q;
                wr_ok_q  <= 1'b0;
            end else begin
                if (ev_rise) begin
                    if (state_q == S_DEV || state_q == S_ADR || state_q == S_WR) begin
                        shreg_q  <= {shreg_q[6:0], filt[0]};
                        bitcnt_q <= bitcnt_q + 4'd1;
                    end
                    if (state_q == S_RD)     bitcnt_q <= bitcnt_q + 4'd1;
                    if (state_q == S_RD_ACK) mack_q   <= ~filt[0];
                end
                if (ev_fall) begin
                    case (state_q)
                        S_DEV: if (byte_done) begin
                            rnw_q  <= shreg_q[0];
                            sda_oe <= id_ok;
                        end
                        S_DEV_ACK: begin
                            bitcnt_q <= '0;
                            if (rnw_q) begin
                                tx_q   <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        S_ADR: if (byte_done) begin
                            ptr_q  <= shreg_q[ADDR_W-1:0];
                            sda_oe <= 1'b1;
                        end
                        S_ADR_ACK: begin
                            sda_oe   <= 1'b0;
                            bitcnt_q <= '0;
                        end
                        S_WR: if (byte_done && wp_n) begin
                            sda_oe    <= 1'b1;
                            reg_we    <= 1'b1;
                            reg_wdata <= shreg_q;
                            wr_ok_q   <= 1'b1;
                        end
                        S_WR_ACK: sda_oe <= 1'b0;
                        S_RD: begin
                            if (byte_done) begin
                                sda_oe <= 1'b0;
                                ptr_q  <= ptr_next;
                            end else begin
                                tx_q   <= {tx_q[6:0], 1'b0};
                                sda_oe <= ~tx_q[6];
                            end
                        end
                        S_RD_ACK: begin
                            bitcnt_q <= '0;
                            if (mack_q) begin
                                tx_q   <= reg_rdata;
                                sda_oe <= ~reg_rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we); // R4
    AST_WE_NEEDS_WP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> $past(wp_n)); // R5
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) |-> !sda_oe); // R9
    AST_OE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> (state_q == S_DEV_ACK || state_q == S_ADR_ACK ||
                    state_q == S_WR_ACK  || state_q == S_RD)); // R3
    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RD_ACK && $past(state_q) == S_RD) |->
        (ptr_q == (($past(ptr_q) == PTR_LAST) ? '0 : $past(ptr_q) + ADDR_W'(1)))); // R7
    AST_STOP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stop |=> !wr_stop); // R10
endmodule

// File: tb/twowire_slave_test.sv
`timescale 1ns/1ps
module twowire_slave_test;
    localparam int P = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1, m_sda = 1'b1;
    logic       sda_oe, sda_line;
    logic [2:0] strap = 3'b101;
    logic       wp_n = 1'b1, busy = 1'b0;
    logic [3:0] reg_addr;
    logic [7:0] reg_rdata, reg_wdata;
    logic       reg_we, wr_stop;

    logic [7:0] mem [16];
    int we_cnt = 0, stop_cnt = 0, busy_oe = 0;
    int n_checks = 0, n_err = 0;
    bit done = 0;

    always #4 clk = ~clk;

    assign sda_line  = m_sda & ~sda_oe;
    assign reg_rdata = mem[reg_addr];

    twowire_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .strap(strap), .wp_n(wp_n), .busy(busy), .reg_addr(reg_addr),
        .reg_rdata(reg_rdata), .reg_wdata(reg_wdata), .reg_we(reg_we), .wr_stop(wr_stop)
    );

    initial for (int i = 0; i < 16; i++) mem[i] = 8'h10 + 8'(i);

    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (wr_stop) stop_cnt <= stop_cnt + 1;
        if (busy && sda_oe) busy_oe <= busy_oe + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1; tick(P); m_scl = 1; tick(P); m_sda = 0; tick(P); m_scl = 0; tick(P);
    endtask

    task automatic bus_stop();
        m_sda = 0; tick(P); m_scl = 1; tick(P); m_sda = 1; tick(P);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(P); m_scl = 1; tick(P); m_scl = 0; tick(P);
        end
        m_sda = 1; tick(P); m_scl = 1; tick(P); ack = !sda_line; m_scl = 0; tick(P);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(P); m_scl = 1; tick(P); b[i] = sda_line; m_scl = 0;
        end
        tick(P); m_sda = give_ack ? 1'b0 : 1'b1; tick(P);
        m_scl = 1; tick(P); m_scl = 0; tick(P); m_sda = 1;
    endtask

    bit a1, a2, a3, a4, oe_after;
    logic [7:0] rbuf [4];

    task automatic do_write(input logic [2:0] id, input logic [7:0] adr, input logic [7:0] dat);
        bus_start();
        send_byte({4'b1010, id, 1'b0}, a1);
        send_byte(adr, a2);
        send_byte(dat, a3);
        bus_stop();
        tick(P);
    endtask

    task automatic do_read(input logic [7:0] adr, input int n);
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, a1);
        send_byte(adr, a2);
        bus_start();
        send_byte({4'b1010, strap, 1'b1}, a3);
        for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
        tick(P);
        oe_after = sda_oe;
        bus_stop();
        tick(P);
    endtask

    // {address, data} write vectors, each read back afterwards
    localparam logic [11:0] VEC [4] = '{
        {4'd0, 8'h3C}, {4'd3, 8'hA5}, {4'd6, 8'h01}, {4'd8, 8'h80}
    };

    initial begin
        int w0, s0;
        logic [7:0] keep;
        tick(5);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 reg_we", reg_we, 0);
        check("R1 wr_stop", wr_stop, 0);
        rst_n = 1;
        tick(10);
        check("R1 sda_oe after release", sda_oe, 0);

        for (int v = 0; v < 4; v++) begin
            w0 = we_cnt; s0 = stop_cnt;
            do_write(strap, {4'd0, VEC[v][11:8]}, VEC[v][7:0]);
            check("R3 device ack", a1, 1);
            check("R4 address ack", a2, 1);
            check("R4 data ack", a3, 1);
            check("R4 one strobe", we_cnt - w0, 1);
            check("R4 stored byte", mem[VEC[v][11:8]], VEC[v][7:0]);
            check("R10 stop pulse", stop_cnt - s0, 1);
            do_read({4'd0, VEC[v][11:8]}, 1);
            check("R6 read back", rbuf[0], VEC[v][7:0]);
        end

        // Sequential read across the wrap point
        s0 = stop_cnt;
        do_read(8'd7, 4);
        check("R6 header acks", {a1, a2, a3}, 3'b111);
        check("R6 byte at 7", rbuf[0], mem[7]);
        check("R7 byte at 8", rbuf[1], mem[8]);
        check("R7 wrap to 0", rbuf[2], mem[0]);
        check("R7 byte at 1", rbuf[3], mem[1]);
        check("R8 release after nack", oe_after, 0);
        check("R10 no pulse after read", stop_cnt - s0, 0);

        do_read(8'd3, 2);
        check("R6 byte at 3", rbuf[0], mem[3]);
        check("R6 byte at 4", rbuf[1], mem[4]);

        // Write protect
        wp_n = 0; tick(P);
        w0 = we_cnt; s0 = stop_cnt; keep = mem[1];
        do_write(strap, 8'd1, 8'hEE);
        check("R5 header acked", {a1, a2}, 2'b11);
        check("R5 data not acked", a3, 0);
        check("R5 no strobe", we_cnt - w0, 0);
        check("R5 byte kept", mem[1], keep);
        check("R10 no pulse after refused write", stop_cnt - s0, 0);
        wp_n = 1; tick(P);

        // Strap mismatch
        w0 = we_cnt;
        do_write(3'b011, 8'd2, 8'h77);
        check("R3 mismatch not acked", {a1, a2, a3}, 3'b000);
        check("R3 mismatch no strobe", we_cnt - w0, 0);

        // STOP abandons a write; bytes after it are ignored
        w0 = we_cnt;
        bus_start();
        send_byte({4'b1010, strap, 1'b0}, a1);
        send_byte(8'd2, a2);
        bus_stop();
        send_byte(8'h99, a3);
        send_byte(8'h98, a4);
        bus_stop();
        check("R2 header acked", {a1, a2}, 2'b11);
        check("R2 no ack after stop", {a3, a4}, 2'b00);
        check("R2 no strobe after stop", we_cnt - w0, 0);

        // Busy register block
        busy = 1; tick(P);
        w0 = we_cnt; keep = mem[2];
        do_write(strap, 8'd2, 8'h55);
        check("R9 no acks while busy", {a1, a2, a3}, 3'b000);
        check("R9 byte kept", mem[2], keep);
        check("R9 line released", busy_oe, 0);
        busy = 0; tick(P);
        do_write(strap, 8'd2, 8'h55);
        check("R9 works after busy", mem[2], 8'h55);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end
endmodule